// File: doc/BRIEF.md
# Bus Arbiter With Safe Grant Handoff

This block is the central arbiter for a shared parallel bus with `N` masters. Each master drives an active-low request line and receives an active-low grant line. The arbiter also watches the shared frame and initiator-ready lines, both active low. When both are high the bus looks idle. When either is low a transaction is in progress. Grants go to the requesting master with the lowest index. A master that holds the grant but has not yet started can lose it to a higher-priority request.

A master may hold its grant while it is still driving its address phase, before it asserts frame. Handing the grant straight to another master while the bus looks idle could therefore make two masters drive the bus at once. The arbiter prevents this. On an idle-looking bus it takes the grant away, leaves every grant released for one clock, and only then grants the new owner. While a transaction is running, the grant can move in a single clock.

A master can keep requesting while it holds the grant and never start. Once it has done so for sixteen consecutive idle clocks, the arbiter marks it broken. After that, its requests are ignored until reset or until a per-master clear input is pulsed. When no eligible master requests, the grant stays with the last owner.

Top module: `safe_handoff_arbiter`

## Requirements
- R1: During and after reset every grant output is high (released) and every broken flag is 0.
- R2: At most one grant output is low in any cycle.
- R3: With no current owner, the grant goes in the next clock to the eligible requester with the lowest index. Bit i of each vector belongs to master i. A new grant always goes to a master that was requesting and that has no eligible requester with a lower index.
- R4: When no eligible master requests, the current owner keeps its grant (parking), whether or not it still requests.
- R5: When the grant must move while the bus looks idle (frame high and initiator-ready high), all grants are released for exactly one clock, and the new owner is granted in the clock after that. This covers preemption by a higher-priority request and an owner that has dropped its request.
- R6: When the grant must move while frame or initiator-ready is low, the old grant is released and the new one asserted at the same clock edge, with no empty clock.
- R7: A broken flag is set when its master has held the grant and kept requesting through 16 consecutive idle clocks. The flag is visible after the 16th clock edge that follows the grant. An active frame or initiator-ready, a dropped request or a change of owner restarts the count.
- R8: A broken master's requests are ignored. Its grant is withdrawn at the next clock edge after its flag is set (bus idle), and lower-priority requesters are served instead of it.
- R9: Pulsing the clear input bit i high for one clock resets broken flag i at that edge, and clear takes precedence over a simultaneous set. From the next clock onward, master i's requests are honoured again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | N | Per-master bus request, active low |
| frame_n | input | 1 | Shared frame signal, active low |
| irdy_n | input | 1 | Shared initiator-ready signal, active low |
| brk_clr | input | N | Per-master clear of the broken flag, active high |
| gnt_n | output | N | Per-master bus grant, active low |
| broken | output | N | Per-master broken (locked-out) status |

## Verification
The assertions assume that frame and initiator-ready are sampled synchronously and only matter while some master owns the bus. They also assume that a clear pulse arrives as a level sampled at a clock edge. The handoff properties compare each new grant with the previous cycle's bus activity and requests, so they depend on the request and bus lines being stable around the edge. The bench keeps within these assumptions by changing every input only at the falling clock edge. It asserts frame only while an owner exists, as a real master would, and it drops requests before leaving a bus idle, so that the timeout counts only in the scenarios built to reach it.

// File: rtl/arb_pkg.sv
// Package: shared types for the safe-handoff arbiter.
// Assumes: nothing; holds only the handoff action encoding.
package arb_pkg;

    // Decision the grant controller takes in a cycle.
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,  // keep the present grant vector
        ACT_GRANT   = 2'd1,  // bus unowned, grant the winner
        ACT_SWITCH  = 2'd2,  // transaction running, move grant directly
        ACT_RELEASE = 2'd3   // bus looks idle, drop grant for a dead clock
    } handoff_act_e;

endpackage

// File: rtl/arb_prio_pick.sv
// Module: fixed-priority picker. The lowest set index of req wins.
// Assumes: req is already masked for ineligible masters.
module arb_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win
);

    // taken[i] is high when some index below i is requesting
    logic [N:0] taken;

    assign taken[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chain
            // Purpose: pass the winning slot down the priority chain
            assign win[gi]     = req[gi] & ~taken[gi];
            assign taken[gi+1] = taken[gi] | req[gi];
        end
    endgenerate

endmodule

// File: rtl/arb_grant_ctrl.sv
// Module: grant register and handoff decision.
// Moves the grant directly while a transaction runs. On an idle-looking
// bus it releases first and regrants one clock later. It parks on the
// last owner when nobody eligible requests.
// Assumes: win is one-hot or zero, broken is registered status.
module arb_grant_ctrl
    import arb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] win,
    input  logic [N-1:0] req,
    input  logic [N-1:0] broken,
    input  logic         busy,
    output logic [N-1:0] gnt_q,
    output logic [N-1:0] gnt_nxt
);

    localparam logic [N-1:0] NONE = '0;

    handoff_act_e act;
    logic         owner_brk;

    assign owner_brk = |(gnt_q & broken);

    // Purpose: choose the handoff action and the next grant vector
    always_comb begin
        act     = ACT_HOLD;
        gnt_nxt = gnt_q;
        if (gnt_q == NONE) begin
            if (win != NONE) begin
                act     = ACT_GRANT;
                gnt_nxt = win;
            end
        end else if (win == gnt_q) begin
            act = ACT_HOLD;
        end else if (win == NONE && !owner_brk) begin
            act = ACT_HOLD;
        end else if (busy) begin
            act     = ACT_SWITCH;
            gnt_nxt = win;
        end else begin
            act     = ACT_RELEASE;
            gnt_nxt = NONE;
        end
    end

    // Purpose: register the grant vector
    always_ff @(posedge clk) begin
        if (!rst_n) gnt_q <= NONE;
        else        gnt_q <= gnt_nxt;
    end

    // R2: never more than one owner
    p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_q));

    // R5: a move between two owners without a gap needs a running transaction
    p_idle_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gnt_q) != NONE && gnt_q != NONE && gnt_q != $past(gnt_q))
        |-> $past(busy));

    // R3: a new owner was requesting and had no eligible lower-index rival
    p_new_owner_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != NONE && gnt_q != $past(gnt_q))
        |-> ((gnt_q & $past(req)) != NONE
             && ((gnt_q - N'(1)) & $past(req) & ~$past(broken)) == NONE));

    // R8: a broken master is never handed a fresh grant
    p_no_broken_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != NONE && gnt_q != $past(gnt_q))
        |-> ((gnt_q & $past(broken)) == NONE));

endmodule

// File: rtl/arb_stall_watch.sv
// Module: idle-owner watchdog and broken flags.
// Counts clocks in which the owner keeps requesting, the bus stays idle
// and the grant is not moving. On the LIMIT-th such clock the owner is
// flagged broken. Clears take precedence over a set in the same cycle.
// Assumes: gnt_q is one-hot or zero.
module arb_stall_watch #(
    parameter int N     = 4,
    parameter int LIMIT = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] gnt_q,
    input  logic [N-1:0] gnt_nxt,
    input  logic [N-1:0] req,
    input  logic         busy,
    input  logic [N-1:0] clr,
    output logic [N-1:0] broken
);

    localparam int            CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] idle_cnt;
    logic          stalling;
    logic          expire;

    assign stalling = (gnt_q != '0) && (gnt_nxt == gnt_q) && !busy
                      && (|(gnt_q & req));
    assign expire   = stalling && (idle_cnt == LAST);

    // Purpose: count consecutive stalled-owner idle clocks
    always_ff @(posedge clk) begin
        if (!rst_n)                 idle_cnt <= '0;
        else if (!stalling || expire) idle_cnt <= '0;
        else                        idle_cnt <= idle_cnt + 1'b1;
    end

    // Purpose: set the owner's broken flag on expiry, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n) broken <= '0;
        else        broken <= (broken | (expire ? gnt_q : '0)) & ~clr;
    end

    // R7: the idle count never passes its limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LAST);

    // R7: a flag can only newly rise for the master that held the grant
    p_flag_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((broken & ~$past(broken) & ~$past(gnt_q)) == '0));

    // R9: a clear always wins at its edge
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((broken & $past(clr)) == '0));

endmodule

// File: rtl/safe_handoff_arbiter.sv
// Module: top of the safe-handoff bus arbiter.
// Converts active-low pins, masks broken masters out of the request set,
// and wires picker, grant controller and stall watchdog together.
// Assumes: all inputs synchronous to clk.
module safe_handoff_arbiter #(
    parameter int N          = 4,
    parameter int IDLE_LIMIT = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_n,
    input  logic         frame_n,
    input  logic         irdy_n,
    input  logic [N-1:0] brk_clr,
    output logic [N-1:0] gnt_n,
    output logic [N-1:0] broken
);

    logic [N-1:0] req;
    logic [N-1:0] elig;
    logic [N-1:0] win;
    logic [N-1:0] gnt_q;
    logic [N-1:0] gnt_nxt;
    logic         busy;

    // Purpose: decode pins into active-high requests and bus activity
    assign req   = ~req_n;
    assign busy  = ~frame_n | ~irdy_n;
    assign elig  = req & ~broken;
    assign gnt_n = ~gnt_q;

    arb_prio_pick #(.N(N)) u_pick (
        .req (elig),
        .win (win)
    );

    arb_grant_ctrl #(.N(N)) u_gnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .win     (win),
        .req     (req),
        .broken  (broken),
        .busy    (busy),
        .gnt_q   (gnt_q),
        .gnt_nxt (gnt_nxt)
    );

    arb_stall_watch #(.N(N), .LIMIT(IDLE_LIMIT)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .gnt_q   (gnt_q),
        .gnt_nxt (gnt_nxt),
        .req     (req),
        .busy    (busy),
        .clr     (brk_clr),
        .broken  (broken)
    );

    // R1: out of reset nothing is granted and nothing is flagged
    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (gnt_n == '1 && broken == '0));

endmodule

// File: tb/safe_handoff_arbiter_test.sv
module safe_handoff_arbiter_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_n = '1;
    logic         frame_n = 1'b1;
    logic         irdy_n = 1'b1;
    logic [N-1:0] brk_clr = '0;
    logic [N-1:0] gnt_n;
    logic [N-1:0] broken;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    safe_handoff_arbiter #(.N(N), .IDLE_LIMIT(16)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (req_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .brk_clr (brk_clr),
        .gnt_n   (gnt_n),
        .broken  (broken)
    );

    task automatic chk(input string tag, input logic [N-1:0] got,
                       input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1; brk_clr = '0;
        tick(3);
        chk("R1 grants in reset", gnt_n, 4'b1111);
        chk("R1 flags in reset", broken, 4'b0000);
        rst_n = 1'b1;
        tick(1);
        chk("R1 grants after reset", gnt_n, 4'b1111);
    endtask

    task automatic t_first_and_park();
        req_n = 4'b1011;                       // master 2 requests
        tick(1);
        chk("R3 first grant to m2", gnt_n, 4'b1011);
        req_n = 4'b0011;                       // m2 and m3 and (none lower)
        req_n = 4'b1111;
        tick(3);
        chk("R4 parked on m2", gnt_n, 4'b1011);
    endtask

    task automatic t_idle_preempt();
        req_n = 4'b1010;                       // m2 holds, m0 arrives, idle bus
        tick(1);
        chk("R5 release on idle bus", gnt_n, 4'b1111);
        tick(1);
        chk("R5 R3 m0 after dead clock", gnt_n, 4'b1110);
        req_n = 4'b1111;
        tick(1);
        chk("R4 parked on m0", gnt_n, 4'b1110);
        chk("R2 single grant", 4'($countones(~gnt_n)), 4'd1);
    endtask

    task automatic t_busy_switch();
        frame_n = 1'b0;                        // m0 transaction running
        req_n   = 4'b0111;                     // only m3 requests
        tick(1);
        chk("R6 direct move to m3", gnt_n, 4'b0111);
        req_n   = 4'b1111;
        frame_n = 1'b1;
        irdy_n  = 1'b0;
        req_n   = 4'b1101;                     // m1 higher than owner m3
        tick(1);
        chk("R6 direct move to m1", gnt_n, 4'b1101);
        irdy_n  = 1'b1;
        req_n   = 4'b1111;
        tick(2);
        chk("R7 no flag when not requesting", broken, 4'b0000);
    endtask

    task automatic t_timeout();
        do_reset();
        req_n = 4'b1101;                       // m1 requests, never starts
        tick(1);
        chk("R3 m1 granted", gnt_n, 4'b1101);
        tick(15);
        chk("R7 no flag after 15 idle", broken, 4'b0000);
        tick(1);
        chk("R7 flag after 16 idle", broken, 4'b0010);
        tick(1);
        chk("R8 broken m1 grant withdrawn", gnt_n, 4'b1111);
        tick(2);
        chk("R8 m1 request ignored", gnt_n, 4'b1111);
        req_n = 4'b0101;                       // m3 joins, m1 still asks
        tick(1);
        chk("R8 lower m3 served", gnt_n, 4'b0111);
        req_n = 4'b1101;                       // m3 parks, m1 still asks
        tick(1);
        chk("R8 m1 still locked out", gnt_n, 4'b0111);
        brk_clr = 4'b0010;
        tick(1);
        brk_clr = 4'b0000;
        chk("R9 flag cleared", broken, 4'b0000);
        tick(1);
        chk("R9 R5 release for m1", gnt_n, 4'b1111);
        tick(1);
        chk("R9 m1 granted again", gnt_n, 4'b1101);
        req_n = 4'b1111;
        tick(1);
    endtask

    task automatic t_count_restart();
        do_reset();
        req_n = 4'b1110;                       // m0 requests
        tick(1);
        chk("R3 m0 granted", gnt_n, 4'b1110);
        tick(10);
        frame_n = 1'b0;                        // activity restarts count
        tick(1);
        frame_n = 1'b1;
        tick(15);
        chk("R7 count restarted by frame", broken, 4'b0000);
        tick(1);
        chk("R7 flag 16 after activity", broken, 4'b0001);
        brk_clr = 4'b0001;
        req_n   = 4'b1111;
        tick(1);
        brk_clr = 4'b0000;
        chk("R9 clear m0", broken, 4'b0000);
    endtask

    initial begin
        do_reset();
        t_first_and_park();
        t_idle_preempt();
        t_busy_switch();
        t_timeout();
        t_count_restart();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule